// File: doc/BRIEF.md
# Dual Write-Combining Store Queue

This block collects processor stores into two line-sized buffers and sends each buffer to external memory as one whole-line burst. A store whose address falls in a fixed 64 MiB window is not sent to memory. Its address picks one of the two 32-byte buffers and a 32-bit slot inside it, and the data is written into that slot. The write may be 32 or 64 bits wide. A separate flush command, also addressed into the window, starts a burst of eight 32-bit beats from the selected buffer. The burst goes out through a valid/ready write master to a 32-byte-aligned destination.

The two buffers work as a ping-pong pair. Software fills one buffer and flushes it, then goes on to fill the other while the first drains. Only an access to a buffer that is still draining is held back, through a stall output. The destination address is built from the flush address and a 3-bit upper-address value for each buffer. That value is latched when the flush is accepted.

Top module: `wcsq_top`

## Requirements
- R1: A write or flush whose address bits [31:26] are not 6'b111000 changes no buffer content, starts no burst, and raises neither stall nor error.
- R2: For an in-window write, address bit 5 picks the buffer (0 = first, 1 = second) and bits [4:2] pick the slot. Bits [25:6] have no effect on where the data lands.
- R3: A 64-bit write (wr_quad = 1) to slot k stores wr_data[31:0] in slot k and wr_data[63:32] in slot k+1 of the same buffer.
- R4: An in-window write with address bits [1:0] not 00, or a 64-bit write with address bit 2 set, raises align_err in the same cycle, never raises wr_stall, and leaves the buffers unchanged.
- R5: An accepted flush produces exactly eight beats carrying slots 0 to 7 in ascending order. One beat transfers per cycle with mem_valid and mem_ready both high. mem_last is high on the eighth beat only.
- R6: mem_addr during a burst equals {upper value of that buffer, flush address bits [25:5], 5'b00000}, using the values present when the flush was accepted.
- R7: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_data and mem_last stay unchanged on the next cycle.
- R8: An aligned in-window write to a buffer that is draining or waiting to drain raises wr_stall and is not stored. It is stored once the stall drops.
- R9: An aligned write to the buffer that is not draining is accepted without a stall cycle.
- R10: A flush to a buffer that is draining or waiting raises fl_stall until that buffer's burst ends. A flush to the other buffer is accepted at once and its burst follows the current one.
- R11: The draining state of a buffer ends at the clock edge where its last beat is accepted, so its stall is low in the very next cycle, and mem_valid is low in that cycle.
- R12: After reset, mem_valid is low, no stall is raised, and every slot of both buffers reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Store request |
| wr_addr | input | 32 | Store address |
| wr_data | input | 64 | Store data; upper half used only for 64-bit stores |
| wr_quad | input | 1 | 1 = 64-bit store, 0 = 32-bit store |
| wr_stall | output | 1 | Store held back; keep the request steady |
| align_err | output | 1 | Store dropped for misalignment |
| fl_req | input | 1 | Flush request |
| fl_addr | input | 32 | Flush address |
| fl_stall | output | 1 | Flush held back; keep the request steady |
| q0_hi | input | 3 | Upper destination bits for the first buffer |
| q1_hi | input | 3 | Upper destination bits for the second buffer |
| mem_valid | output | 1 | Burst beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 29 | Line-aligned burst destination |
| mem_data | output | 32 | Beat data |
| mem_last | output | 1 | Final beat of the burst |

## Verification
The bench holds memory ready low while a burst is in flight and probes the draining buffer and the idle buffer with both writes and flushes. A design that stalled the wrong buffer would either add a penalty cycle to the idle buffer or let a store corrupt the beats already in flight. It also queues a second flush behind a running burst and then re-flushes the first buffer with a new address. This catches a design that drops a pending burst, serves the buffers out of order, or reuses an old destination. Alternating ready exposes data or address that moves while a beat is waiting. Misaligned 64-bit stores and out-of-window stores must leave the buffer content untouched. The stall-release check requires the stall to drop in the cycle right after the last beat, which catches a busy flag cleared a cycle late or early.

// File: rtl/wcsq_pkg.sv
package wcsq_pkg;

    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 32;
    localparam int SLOT_N   = 8;
    localparam int SLOT_W   = $clog2(SLOT_N);
    localparam int BYTE_LSB = $clog2(WORD_W / 8);
    localparam int LINE_LSB = BYTE_LSB + SLOT_W;
    localparam int TAG_LSB  = 26;
    localparam int TAG_W    = ADDR_W - TAG_LSB;
    localparam logic [TAG_W-1:0] TAG_VAL = 6'b111000;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic  hit;
        logic  qsel;
        slot_t slot;
        logic  misalign;
    } wr_dec_t;

    typedef struct packed {
        logic hit;
        logic qsel;
    } fl_dec_t;

    function automatic logic tag_hit(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:TAG_LSB] == TAG_VAL;
    endfunction

endpackage

// File: rtl/wcsq_decode.sv
module wcsq_decode
    import wcsq_pkg::*;
(
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_quad,
    input  logic [ADDR_W-1:0] fl_addr,
    output wr_dec_t           wd,
    output fl_dec_t           fd
);
    always_comb begin
        wd.hit      = tag_hit(wr_addr);
        wd.qsel     = wr_addr[LINE_LSB];
        wd.slot     = wr_addr[LINE_LSB-1:BYTE_LSB];
        wd.misalign = (|wr_addr[BYTE_LSB-1:0]) | (wr_quad & wr_addr[BYTE_LSB]);
        fd.hit      = tag_hit(fl_addr);
        fd.qsel     = fl_addr[LINE_LSB];
    end
endmodule

// File: rtl/wcsq_line.sv
module wcsq_line
    import wcsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_lo,
    input  logic              we_hi,
    input  slot_t             slot,
    input  logic [2*WORD_W-1:0] din,
    input  slot_t             rd_slot,
    output word_t             rd_word
);
    word_t mem [SLOT_N];
    slot_t hi_slot;

    // a 64-bit store starts on an even slot, so its upper half goes to slot|1
    assign hi_slot = slot | slot_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOT_N; i++) mem[i] <= '0;
        end else begin
            if (we_lo) mem[slot]    <= din[WORD_W-1:0];
            if (we_hi) mem[hi_slot] <= din[2*WORD_W-1:WORD_W];
        end
    end

    assign rd_word = mem[rd_slot];
endmodule

// File: rtl/wcsq_drain.sv
module wcsq_drain
    import wcsq_pkg::*;
#(
    parameter int DEST_W = 29
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fl_go,
    input  logic              fl_q,
    input  logic [DEST_W-1:0] fl_dest,
    input  logic              mem_ready,
    output logic [1:0]        busy,
    output logic              rd_q,
    output slot_t             rd_slot,
    output logic              mem_valid,
    output logic              mem_last,
    output logic [DEST_W-1:0] mem_addr
);
    logic [DEST_W-1:0] dest_q [2];
    logic              act;
    logic              cur;
    slot_t             beat;
    logic              pick;
    logic              at_end;

    // both pending: take the one not served last; else the single pending one
    assign pick   = (busy == 2'b11) ? ~cur : busy[1];
    assign at_end = (beat == slot_t'(SLOT_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= '0;
            dest_q[0] <= '0;
            dest_q[1] <= '0;
            act       <= 1'b0;
            cur       <= 1'b0;
            beat      <= '0;
        end else begin
            if (fl_go) begin
                busy[fl_q]   <= 1'b1;
                dest_q[fl_q] <= fl_dest;
            end
            if (!act) begin
                if (|busy) begin
                    act  <= 1'b1;
                    cur  <= pick;
                    beat <= '0;
                end
            end else if (mem_ready) begin
                if (at_end) begin
                    act       <= 1'b0;
                    busy[cur] <= 1'b0;
                end else begin
                    beat <= beat + slot_t'(1);
                end
            end
        end
    end

    assign mem_valid = act;
    assign mem_last  = act & at_end;
    assign mem_addr  = dest_q[cur];
    assign rd_q      = cur;
    assign rd_slot   = beat;
endmodule

// File: rtl/wcsq_top.sv
module wcsq_top
    import wcsq_pkg::*;
#(
    parameter int HI_W = 3,
    localparam int DEST_W = HI_W + TAG_LSB
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_req,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [2*WORD_W-1:0] wr_data,
    input  logic                wr_quad,
    output logic                wr_stall,
    output logic                align_err,
    input  logic                fl_req,
    input  logic [ADDR_W-1:0]   fl_addr,
    output logic                fl_stall,
    input  logic [HI_W-1:0]     q0_hi,
    input  logic [HI_W-1:0]     q1_hi,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [DEST_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_data,
    output logic                mem_last
);
    wr_dec_t           wd;
    fl_dec_t           fd;
    logic [1:0]        busy;
    logic              wr_ok;
    logic              wr_go;
    logic              fl_go;
    logic [DEST_W-1:0] fl_dest;
    logic              rd_q;
    slot_t             rd_slot;
    word_t             line_rd [2];
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{wr_addr[TAG_LSB-1:LINE_LSB+1], fl_addr[LINE_LSB-1:0]};

    wcsq_decode u_dec (
        .wr_addr (wr_addr),
        .wr_quad (wr_quad),
        .fl_addr (fl_addr),
        .wd      (wd),
        .fd      (fd)
    );

    assign wr_ok     = wr_req & wd.hit & ~wd.misalign;
    assign wr_stall  = wr_ok & busy[wd.qsel];
    assign wr_go     = wr_ok & ~busy[wd.qsel];
    assign align_err = wr_req & wd.hit & wd.misalign;

    assign fl_stall  = fl_req & fd.hit & busy[fd.qsel];
    assign fl_go     = fl_req & fd.hit & ~busy[fd.qsel];
    assign fl_dest   = {(fd.qsel ? q1_hi : q0_hi),
                        fl_addr[TAG_LSB-1:LINE_LSB],
                        {LINE_LSB{1'b0}}};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic we_lo;
        assign we_lo = wr_go & (wd.qsel == 1'(g));
        wcsq_line u_line (
            .clk     (clk),
            .rst     (rst),
            .we_lo   (we_lo),
            .we_hi   (we_lo & wr_quad),
            .slot    (wd.slot),
            .din     (wr_data),
            .rd_slot (rd_slot),
            .rd_word (line_rd[g])
        );
    end

    wcsq_drain #(.DEST_W(DEST_W)) u_drain (
        .clk       (clk),
        .rst       (rst),
        .fl_go     (fl_go),
        .fl_q      (fd.qsel),
        .fl_dest   (fl_dest),
        .mem_ready (mem_ready),
        .busy      (busy),
        .rd_q      (rd_q),
        .rd_slot   (rd_slot),
        .mem_valid (mem_valid),
        .mem_last  (mem_last),
        .mem_addr  (mem_addr)
    );

    assign mem_data = line_rd[rd_q];
endmodule

// File: rtl/wcsq_chk.sv
module wcsq_chk
    import wcsq_pkg::*;
#(
    parameter int DEST_W = 29
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_req,
    input logic              wr_stall,
    input logic              align_err,
    input logic              fl_req,
    input logic              fl_stall,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [DEST_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_data,
    input logic              mem_last
);
    slot_t beats_seen;

    always_ff @(posedge clk) begin
        if (rst) beats_seen <= '0;
        else if (mem_valid && mem_ready) beats_seen <= beats_seen + slot_t'(1);
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                      && $stable(mem_data) && $stable(mem_last)));

    // R5
    last_on_eighth_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_last == (beats_seen == slot_t'(SLOT_N - 1))));

    // R4
    err_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        align_err |-> (!wr_stall && wr_req));

    // R8
    wr_stall_req_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stall |-> wr_req);

    // R10
    fl_stall_req_chk: assert property (@(posedge clk) disable iff (rst)
        fl_stall |-> fl_req);

    // R11
    release_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_last) |=> !mem_valid);
endmodule

bind wcsq_top wcsq_chk #(.DEST_W(DEST_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_req),
    .wr_stall  (wr_stall),
    .align_err (align_err),
    .fl_req    (fl_req),
    .fl_stall  (fl_stall),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_last  (mem_last)
);

// File: tb/tb_wcsq_top.sv
module tb_wcsq_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_req, wr_quad, fl_req;
    logic [31:0] wr_addr, fl_addr;
    logic [63:0] wr_data;
    logic        wr_stall, align_err, fl_stall;
    logic [2:0]  q0_hi, q1_hi;
    logic        mem_valid, mem_ready, mem_last;
    logic [28:0] mem_addr;
    logic [31:0] mem_data;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] exp_q [2][8];
    logic [31:0] cap_data [64];
    logic [28:0] cap_addr [64];
    logic        cap_last [64];
    int          cap_n = 0;
    logic        last_hs = 1'b0;
    int          stab_err = 0;
    logic        hold_prev = 1'b0;
    logic [31:0] prev_data;
    logic [28:0] prev_addr;
    logic        prev_last;
    logic        ready_on = 1'b1;
    logic        ready_alt = 1'b0;
    logic        tgl = 1'b0;

    always #5 clk = ~clk;

    wcsq_top dut (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_quad(wr_quad),
        .wr_stall(wr_stall), .align_err(align_err),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_stall(fl_stall),
        .q0_hi(q0_hi), .q1_hi(q1_hi),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_last(mem_last)
    );

    always @(negedge clk) begin
        tgl       = ~tgl;
        mem_ready = ready_on & (ready_alt ? tgl : 1'b1);
    end

    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready && cap_n < 64) begin
            cap_data[cap_n] <= mem_data;
            cap_addr[cap_n] <= mem_addr;
            cap_last[cap_n] <= mem_last;
            cap_n           <= cap_n + 1;
        end
        last_hs <= !rst && mem_valid && mem_ready && mem_last;
        if (!rst && hold_prev &&
            (mem_valid !== 1'b1 || mem_data !== prev_data ||
             mem_addr !== prev_addr || mem_last !== prev_last))
            stab_err <= stab_err + 1;
        hold_prev <= !rst && mem_valid && !mem_ready;
        prev_data <= mem_data;
        prev_addr <= mem_addr;
        prev_last <= mem_last;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] qa(input int q, input int slot, input logic [19:0] junk);
        return 32'hE000_0000 | ({12'h0, junk} << 6) | (32'(q) << 5) | (32'(slot) << 2);
    endfunction

    function automatic logic [28:0] dst(input logic [2:0] hi, input logic [31:0] a);
        return {hi, a[25:5], 5'b0};
    endfunction

    task automatic do_wr(input logic [31:0] a, input logic [63:0] d, input bit quad,
                         output bit err, output bit stalled);
        bit mis;
        bit hit;
        wr_req = 1'b1; wr_addr = a; wr_data = d; wr_quad = quad;
        #1;
        err = align_err;
        stalled = wr_stall;
        while (wr_stall) begin @(negedge clk); #1; end
        hit = (a[31:26] == 6'b111000);
        mis = (a[1:0] != 2'b00) || (quad && a[2]);
        if (hit && !mis) begin
            exp_q[a[5]][a[4:2]] = d[31:0];
            if (quad) exp_q[a[5]][a[4:2] + 3'd1] = d[63:32];
        end
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic do_fl(input logic [31:0] a, output bit stalled);
        fl_req = 1'b1; fl_addr = a;
        #1;
        stalled = fl_stall;
        while (fl_stall) begin @(negedge clk); #1; end
        @(negedge clk);
        fl_req = 1'b0;
    endtask

    task automatic wait_beats(input int target, input string req);
        int t = 0;
        while (cap_n < target && t < 3000) begin @(negedge clk); t++; end
        chk(cap_n >= target, req, "beat count", 64'(cap_n), 64'(target));
    endtask

    task automatic chk_burst(input int b, input logic [31:0] e [8],
                             input logic [28:0] a, input string req);
        for (int i = 0; i < 8; i++) begin
            chk(cap_data[b+i] == e[i], req, $sformatf("beat %0d data", i),
                64'(cap_data[b+i]), 64'(e[i]));
            chk(cap_addr[b+i] == a, req, $sformatf("beat %0d addr", i),
                64'(cap_addr[b+i]), 64'(a));
            chk(cap_last[b+i] == (i == 7), req, $sformatf("beat %0d last", i),
                64'(cap_last[b+i]), 64'(i == 7));
        end
    endtask

    // R12: reset state and zeroed content
    task automatic t_reset();
        logic [31:0] e [8];
        bit s;
        int b;
        chk(mem_valid == 1'b0, "R12", "mem_valid after reset", 64'(mem_valid), 0);
        chk(wr_stall == 1'b0 && fl_stall == 1'b0, "R12", "stalls after reset",
            64'({wr_stall, fl_stall}), 0);
        e = exp_q[1];
        b = cap_n;
        do_fl(qa(1, 0, 20'h00000), s);
        wait_beats(b + 8, "R12");
        chk_burst(b, e, dst(q1_hi, qa(1, 0, 20'h0)), "R12");
    endtask

    // R2 R5 R6: longword fill with junk middle bits
    task automatic t_basic();
        logic [31:0] e [8];
        bit err, s;
        int b;
        for (int i = 0; i < 8; i++)
            do_wr(qa(0, i, 20'(i * 20'h1357 + 20'h9)), {32'h0, 32'hA000_0000 + 32'(i * 32'h111)}, 1'b0, err, s);
        e = exp_q[0];
        b = cap_n;
        do_fl(qa(0, 3, 20'hA5C3B), s);
        wait_beats(b + 8, "R5");
        chk_burst(b, e, dst(q0_hi, qa(0, 3, 20'hA5C3B)), "R2_R5_R6");
    endtask

    // R1 R3 R4: quad writes, misaligned and out-of-window stores
    task automatic t_quad();
        logic [31:0] e [8];
        bit err, s;
        int b;
        for (int i = 0; i < 8; i += 2) begin
            do_wr(qa(1, i, 20'h0F0F0), {32'hB100_0000 + 32'(i + 1), 32'hB000_0000 + 32'(i)}, 1'b1, err, s);
            chk(err == 1'b0, "R3", "aligned quad no error", 64'(err), 0);
        end
        do_wr(qa(1, 1, 20'h0), 64'hDEAD_DEAD_BEEF_BEEF, 1'b1, err, s);
        chk(err == 1'b1, "R4", "quad at odd slot flags error", 64'(err), 1);
        chk(s == 1'b0, "R4", "misaligned store not stalled", 64'(s), 0);
        do_wr(qa(1, 4, 20'h0) | 32'h2, 64'h0000_0000_CAFE_0002, 1'b0, err, s);
        chk(err == 1'b1, "R4", "low bits set flags error", 64'(err), 1);
        do_wr(qa(1, 3, 20'h0) | 32'h0400_0000, 64'h0000_0000_0BAD_0003, 1'b0, err, s);
        chk(err == 1'b0 && s == 1'b0, "R1", "out-of-window store quiet", 64'({err, s}), 0);
        b = cap_n;
        do_fl(32'h1000_0020, s);
        repeat (6) @(negedge clk);
        chk(cap_n == b && mem_valid == 1'b0, "R1", "out-of-window flush no burst",
            64'(cap_n - b), 0);
        e = exp_q[1];
        do_fl(qa(1, 0, 20'h00111), s);
        wait_beats(b + 8, "R3");
        chk_burst(b, e, dst(q1_hi, qa(1, 0, 20'h00111)), "R1_R3_R4");
    endtask

    // R7: alternating ready
    task automatic t_backpressure();
        logic [31:0] e [8];
        bit err, s;
        int b;
        for (int i = 0; i < 8; i++)
            do_wr(qa(1, i, 20'h3), {32'h0, 32'h7700_0000 | 32'(i * 32'h0101)}, 1'b0, err, s);
        ready_alt = 1'b1;
        e = exp_q[1];
        b = cap_n;
        do_fl(qa(1, 0, 20'h7F00F), s);
        wait_beats(b + 8, "R7");
        repeat (2) @(negedge clk);
        ready_alt = 1'b0;
        chk_burst(b, e, dst(q1_hi, qa(1, 0, 20'h7F00F)), "R7");
        chk(stab_err == 0, "R7", "outputs held under backpressure", 64'(stab_err), 0);
    endtask

    // R8 R9 R10 R11: ping-pong with memory held off
    task automatic t_pingpong();
        logic [31:0] e0 [8];
        bit err, s;
        int b, t;
        for (int i = 0; i < 8; i++)
            do_wr(qa(0, i, 20'h5), {32'h0, 32'hC000_0000 + 32'(i)}, 1'b0, err, s);
        e0 = exp_q[0];
        ready_on = 1'b0;
        b = cap_n;
        do_fl(qa(0, 0, 20'h12345), s);
        repeat (3) @(negedge clk);
        chk(mem_valid == 1'b1, "R5", "burst waiting on ready", 64'(mem_valid), 1);
        do_wr(qa(1, 2, 20'h9), 64'h0000_0000_5151_0002, 1'b0, err, s);
        chk(s == 1'b0, "R9", "write to idle buffer not stalled", 64'(s), 0);
        wr_req = 1'b1; wr_addr = qa(0, 0, 20'h0); wr_data = 64'h0000_0000_EEEE_0000; wr_quad = 1'b0;
        fl_req = 1'b1; fl_addr = qa(0, 0, 20'h0);
        #1;
        chk(wr_stall == 1'b1, "R8", "write to draining buffer stalled", 64'(wr_stall), 1);
        chk(fl_stall == 1'b1, "R10", "flush to draining buffer stalled", 64'(fl_stall), 1);
        fl_req = 1'b0;
        ready_on = 1'b1;
        t = 0;
        while (wr_stall && t < 100) begin @(negedge clk); #1; t++; end
        chk(last_hs == 1'b1, "R11", "stall drops right after last beat", 64'(last_hs), 1);
        chk(mem_valid == 1'b0, "R11", "no beat in release cycle", 64'(mem_valid), 0);
        chk(cap_n == b + 8, "R8", "beats before stalled write lands", 64'(cap_n - b), 8);
        chk_burst(b, e0, dst(q0_hi, qa(0, 0, 20'h12345)), "R8");
        @(negedge clk);
        wr_req = 1'b0;
        exp_q[0][0] = 32'hEEEE_0000;
    endtask

    // R10 R6: queued second burst, then re-flush with new address
    task automatic t_queue();
        logic [31:0] e0 [8];
        logic [31:0] e1 [8];
        bit s;
        int b, t;
        e0 = exp_q[0];
        e1 = exp_q[1];
        ready_on = 1'b0;
        b = cap_n;
        do_fl(qa(0, 0, 20'h0AAAA), s);
        repeat (2) @(negedge clk);
        do_fl(qa(1, 0, 20'h0BBBB), s);
        chk(s == 1'b0, "R10", "flush to other buffer accepted", 64'(s), 0);
        fl_req = 1'b1; fl_addr = qa(0, 0, 20'h0CCCC);
        #1;
        chk(fl_stall == 1'b1, "R10", "re-flush of draining buffer stalled", 64'(fl_stall), 1);
        ready_on = 1'b1;
        t = 0;
        while (fl_stall && t < 100) begin @(negedge clk); #1; t++; end
        @(negedge clk);
        fl_req = 1'b0;
        wait_beats(b + 24, "R10");
        chk_burst(b,      e0, dst(q0_hi, qa(0, 0, 20'h0AAAA)), "R10");
        chk_burst(b + 8,  e1, dst(q1_hi, qa(1, 0, 20'h0BBBB)), "R10");
        chk_burst(b + 16, e0, dst(q0_hi, qa(0, 0, 20'h0CCCC)), "R6_R10");
    endtask

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int q = 0; q < 2; q++)
            for (int i = 0; i < 8; i++) exp_q[q][i] = 32'h0;
        rst = 1'b1;
        wr_req = 1'b0; wr_addr = '0; wr_data = '0; wr_quad = 1'b0;
        fl_req = 1'b0; fl_addr = '0;
        q0_hi = 3'b101; q1_hi = 3'b010;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_quad();
        t_backpressure();
        t_pingpong();
        t_queue();
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule